// File: doc/BRIEF.md
# Daisy-Chain Readout Sequencer

This block sequences the readout of a chain of front-end chips that share one data bus. One sequencer slice per chip sits idle and unpowered until a readout token reaches it. On arrival the slice switches on its digital power, which also enables its clock input buffers. It then places its stored event words on the common bus, one word per cycle in which the bus grant is high. After the last word it hands the token to the next slice and powers down again.

A chip with nothing stored still takes the token and passes it on in the following cycle. A per-slice watchdog bounds how long a slice may keep the token. If the bound is reached, the slice forwards the token, drops its remaining words and raises a sticky error flag for that chip. A chain controller injects the token into the first slice when readout is requested. It reports the end of readout when the token comes back out of the last slice.

The bus word for event i of chip k is that chip's base value plus i, modulo 2^DW. This lets a receiver tell the chip and the event order from the data alone.

Top module: `rdchain_top`

## Requirements
- R1: A `start_i` pulse while `busy_o` is low puts the token into chip 0 in that same cycle and sets `busy_o` from the next cycle on. A `start_i` while `busy_o` is high is ignored: no second token, no extra words.
- R2: Bit k of `pwr_d_o` is high from the cycle after chip k receives the token up to and including the cycle in which chip k issues its token. It is low at all other times.
- R3: A chip holding n events (bits [k*CW +: CW] of `ev_cnt_i`, sampled when the token arrives) puts exactly n words on the bus. Word i equals bits [k*DW +: DW] of `ev_base_i` plus i, modulo 2^DW. Chips appear in chain order 0, 1, ... NCHIP-1.
- R4: At most one chip drives the bus in any cycle, and `bus_data_o` is zero when `bus_valid_o` is low.
- R5: A chip with n > 0 events issues its token as a single-cycle pulse in the cycle after its last word. With a grant that stays high, chip k holds the token for n+1 cycles.
- R6: A chip with zero events emits no word and issues its token in the cycle after it received it.
- R7: If a chip has spent TMO_CYC cycles in its data phase without sending its last word, it issues its token in the next cycle and sets bit k of `err_o`. Its remaining words are dropped. It then holds power for TMO_CYC+1 cycles.
- R8: Bit k of `err_o` stays set until chip k next receives the token, and is cleared then.
- R9: `done_o` is a single-cycle pulse in the cycle the token leaves the last chip. `busy_o` goes low in the next cycle.
- R10: While `grant_i` is low, no word is sent and the chip's word index does not advance. Words resume in order when the grant returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Readout request pulse |
| ev_cnt_i | input | NCHIP*CW | Stored event count per chip |
| ev_base_i | input | NCHIP*DW | Data base value per chip |
| grant_i | input | 1 | Bus grant; a word moves only when high |
| tok_o | output | 1 | Token leaving the last chip |
| bus_data_o | output | DW | Shared bus data |
| bus_valid_o | output | 1 | Bus word valid |
| pwr_d_o | output | NCHIP | Digital power / clock-buffer enable per chip |
| err_o | output | NCHIP | Sticky readout-timeout flag per chip |
| busy_o | output | 1 | Chain readout in progress |
| done_o | output | 1 | End-of-readout pulse |

## Verification
Event-count patterns are swept arithmetically across four chips. The sweep includes all-empty and all-full chains, so the measured start-to-done latency and the per-chip power time separate the empty-chip shortcut from the normal n+1 cycle hold. A periodically dropped grant shows that stalls neither lose nor reorder words. A grant held low throughout makes every non-empty chip time out, which pins the timeout length and the error mask. A clean run afterwards shows that the flags clear. A second start pulse in mid-readout shows that a busy chain ignores it.

// File: rtl/rdchain_pkg.sv
`timescale 1ns/1ps
package rdchain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_PASS = 2'd2
  } chip_st_e;
endpackage

// File: rtl/rdchain_rstsync.sv
`timescale 1ns/1ps
module rdchain_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/rdchain_chip.sv
`timescale 1ns/1ps
module rdchain_chip #(
  parameter int CW      = 6,
  parameter int DW      = 16,
  parameter int TMO_CYC = 160000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [DW-1:0] base_i,
  input  logic          grant_i,
  output logic          tok_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          pwr_o,
  output logic          err_o
);
  import rdchain_pkg::*;

  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  chip_st_e      st_q, st_d;
  logic [CW-1:0] n_q, n_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          err_q, err_d;
  logic          en;

  // Registers move only while the chip holds or receives the token.
  assign en = (st_q != ST_IDLE) || tok_i;

  always_comb begin
    st_d  = st_q;
    n_d   = n_q;
    idx_d = idx_q;
    tmo_d = tmo_q;
    err_d = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (tok_i) begin
          n_d   = cnt_i;
          idx_d = '0;
          tmo_d = '0;
          err_d = 1'b0;
          st_d  = (cnt_i == '0) ? ST_PASS : ST_SEND;
        end
      end
      ST_SEND: begin
        tmo_d = tmo_q + TW'(1);
        if (grant_i) idx_d = idx_q + CW'(1);
        if (grant_i && (idx_q == n_q - CW'(1))) begin
          st_d = ST_PASS;
        end else if (tmo_q == TMO_LAST) begin
          st_d  = ST_PASS;
          err_d = 1'b1;
        end
      end
      ST_PASS: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      n_q   <= '0;
      idx_q <= '0;
      tmo_q <= '0;
      err_q <= 1'b0;
    end else if (en) begin
      st_q  <= st_d;
      n_q   <= n_d;
      idx_q <= idx_d;
      tmo_q <= tmo_d;
      err_q <= err_d;
    end
  end

  assign valid_o = (st_q == ST_SEND) && grant_i;
  assign data_o  = valid_o ? (base_i + DW'(idx_q)) : '0;
  assign tok_o   = (st_q == ST_PASS);
  assign pwr_o   = (st_q != ST_IDLE);
  assign err_o   = err_q;

  assert_pwr_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_o) |-> $past(tok_o));

  assert_tok_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |=> !tok_o);

  assert_empty_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && tok_i && cnt_i == '0) |=> (tok_o && !valid_o));

  assert_err_with_tok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> tok_o);
endmodule

// File: rtl/rdchain_ctrl.sv
`timescale 1ns/1ps
module rdchain_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tok_last_i,
  output logic tok_first_o,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, busy_d;

  assign tok_first_o = start_i && !busy_q;
  assign done_o      = tok_last_i && busy_q;

  always_comb begin
    busy_d = busy_q;
    if (tok_first_o)  busy_d = 1'b1;
    else if (done_o)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_q) |-> !tok_first_o);
endmodule

// File: rtl/rdchain_busmux.sv
`timescale 1ns/1ps
module rdchain_busmux #(
  parameter int N  = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_v,
  input  logic [N*DW-1:0] data_v,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  // Non-driving chips present zero, so an OR tree merges the bus.
  always_comb begin
    valid_o = 1'b0;
    data_o  = '0;
    for (int k = 0; k < N; k++) begin
      valid_o = valid_o | valid_v[k];
      data_o  = data_o | data_v[k*DW +: DW];
    end
  end

  assert_one_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(valid_v));

  assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (data_o == '0));
endmodule

// File: rtl/rdchain_top.sv
`timescale 1ns/1ps
module rdchain_top #(
  parameter int NCHIP   = 24,
  parameter int CW      = 6,
  parameter int DW      = 16,
  parameter int TMO_CYC = 160000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [NCHIP*CW-1:0] ev_cnt_i,
  input  logic [NCHIP*DW-1:0] ev_base_i,
  input  logic              grant_i,
  output logic              tok_o,
  output logic [DW-1:0]     bus_data_o,
  output logic              bus_valid_o,
  output logic [NCHIP-1:0]  pwr_d_o,
  output logic [NCHIP-1:0]  err_o,
  output logic              busy_o,
  output logic              done_o
);
  logic               rst_s_n;
  logic [NCHIP:0]     tok_chain;
  logic [NCHIP-1:0]   valid_v;
  logic [NCHIP*DW-1:0] data_v;

  rdchain_rstsync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  rdchain_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start_i     (start_i),
    .tok_last_i  (tok_chain[NCHIP]),
    .tok_first_o (tok_chain[0]),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  for (genvar k = 0; k < NCHIP; k++) begin : g_chip
    rdchain_chip #(
      .CW      (CW),
      .DW      (DW),
      .TMO_CYC (TMO_CYC)
    ) chip_i (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .tok_i   (tok_chain[k]),
      .cnt_i   (ev_cnt_i[k*CW +: CW]),
      .base_i  (ev_base_i[k*DW +: DW]),
      .grant_i (grant_i),
      .tok_o   (tok_chain[k+1]),
      .valid_o (valid_v[k]),
      .data_o  (data_v[k*DW +: DW]),
      .pwr_o   (pwr_d_o[k]),
      .err_o   (err_o[k])
    );
  end

  rdchain_busmux #(
    .N  (NCHIP),
    .DW (DW)
  ) mux_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .valid_v (valid_v),
    .data_v  (data_v),
    .valid_o (bus_valid_o),
    .data_o  (bus_data_o)
  );

  assign tok_o = tok_chain[NCHIP];

  assert_pwr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(pwr_d_o));
endmodule

// File: tb/rdchain_top_tb_top.sv
`timescale 1ns/1ps
module rdchain_top_tb_top;
  localparam int NCHIP = 4;
  localparam int CW    = 3;
  localparam int DW    = 8;
  localparam int TMO   = 16;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [NCHIP*CW-1:0] ev_cnt_i;
  logic [NCHIP*DW-1:0] ev_base_i;
  logic              grant_i;
  logic              tok_o;
  logic [DW-1:0]     bus_data_o;
  logic              bus_valid_o;
  logic [NCHIP-1:0]  pwr_d_o;
  logic [NCHIP-1:0]  err_o;
  logic              busy_o;
  logic              done_o;

  int n_checks = 0;
  int n_errors = 0;

  rdchain_top #(.NCHIP(NCHIP), .CW(CW), .DW(DW), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ev_cnt_i(ev_cnt_i),
    .ev_base_i(ev_base_i), .grant_i(grant_i), .tok_o(tok_o),
    .bus_data_o(bus_data_o), .bus_valid_o(bus_valid_o), .pwr_d_o(pwr_d_o),
    .err_o(err_o), .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // gmode 0: grant always high, 1: grant low every third cycle, 2: grant never
  task automatic run_case(input int c0, input int c1, input int c2, input int c3,
                          input int boff, input int gmode, input bit restart);
    int n[NCHIP];
    int base[NCHIP];
    int expw[64];
    int nexp, widx, cyc, done_cyc, tok_cnt, exp_done;
    int pwr_cnt[NCHIP];
    logic [NCHIP-1:0] exp_err;
    n[0] = c0; n[1] = c1; n[2] = c2; n[3] = c3;
    nexp = 0; widx = 0; done_cyc = -1; tok_cnt = 0; exp_done = 0; exp_err = '0;
    for (int k = 0; k < NCHIP; k++) begin
      base[k] = (16 * (k + 1) + boff) % 256;
      ev_cnt_i[k*CW +: CW]  = CW'(n[k]);
      ev_base_i[k*DW +: DW] = DW'(base[k]);
      pwr_cnt[k] = 0;
      if (gmode == 2) begin
        exp_done += (n[k] > 0) ? TMO + 1 : 1;
        exp_err[k] = (n[k] > 0);
      end else begin
        exp_done += n[k] + 1;
        for (int i = 0; i < n[k]; i++) begin
          expw[nexp] = (base[k] + i) % 256;
          nexp++;
        end
      end
    end
    for (cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      start_i = (cyc == 0) || (restart && cyc == 2);
      grant_i = (gmode == 0) ? 1'b1 : (gmode == 1) ? ((cyc % 3) != 2) : 1'b0;
      #1;
      if (bus_valid_o) begin
        if (widx < nexp)
          chk(bus_data_o == DW'(expw[widx]), "R3 word value", int'(bus_data_o), expw[widx]);
        else
          chk(1'b0, "R3 extra word", widx, nexp);
        if (!grant_i) chk(1'b0, "R10 word without grant", 1, 0);
        widx++;
      end
      if (!$onehot0(pwr_d_o)) chk(1'b0, "R4 overlapping owners", int'(pwr_d_o), 0);
      for (int k = 0; k < NCHIP; k++) if (pwr_d_o[k]) pwr_cnt[k]++;
      if (tok_o) tok_cnt++;
      if (done_o) begin
        done_cyc = cyc;
        break;
      end
    end
    start_i = 1'b0;
    chk(widx == nexp, "R3 word count", widx, nexp);
    chk(tok_cnt == 1, "R5 last token pulses", tok_cnt, 1);
    if (gmode != 1) begin
      chk(done_cyc == exp_done, "R9 done latency", done_cyc, exp_done);
      for (int k = 0; k < NCHIP; k++) begin
        int ep;
        ep = (gmode == 2 && n[k] > 0) ? TMO + 1 : n[k] + 1;
        chk(pwr_cnt[k] == ep, (n[k] == 0) ? "R6 empty chip power time" :
            (gmode == 2) ? "R7 timeout power time" : "R2 power window", pwr_cnt[k], ep);
      end
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      grant_i = 1'b1;
      #1;
      chk(!done_o && !busy_o, "R9 chain idle after done", int'({done_o, busy_o}), 0);
      chk(pwr_d_o == '0 && !bus_valid_o, "R2 power off after readout", int'(pwr_d_o), 0);
    end
    chk(err_o == exp_err, (gmode == 2) ? "R7 error mask" : "R8 error cleared",
        int'(err_o), int'(exp_err));
  endtask

  initial begin
    #600000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; grant_i = 1'b0;
    ev_cnt_i = '0; ev_base_i = '0;
    repeat (4) @(negedge clk);
    #1;
    chk(pwr_d_o == '0 && err_o == '0 && !tok_o && !bus_valid_o && !done_o && !busy_o,
        "R2 reset state", int'({pwr_d_o, err_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(pwr_d_o == '0 && !busy_o, "R1 idle after reset", int'(busy_o), 0);

    // R3 R5 sweep with steady grant
    for (int p = 0; p < 12; p++)
      run_case((p*3) % 8, (p*3 + 5) % 8, (p*3 + 10) % 8, (p*3 + 15) % 8, p * 7, 0, 1'b0);
    // R6 all empty, then all full
    run_case(0, 0, 0, 0, 0, 0, 1'b0);
    run_case(7, 7, 7, 7, 200, 0, 1'b0);
    // R10 stalled grant
    for (int p = 0; p < 6; p++)
      run_case((p*5) % 8, 7 - p, (p + 3) % 8, p % 2 ? 7 : 0, p * 11, 1, 1'b0);
    // R7 timeout with grant held low
    run_case(3, 0, 5, 1, 9, 2, 1'b0);
    // R8 flags cleared by the next clean pass
    run_case(1, 2, 0, 4, 33, 0, 1'b0);
    // R1 start while busy is ignored
    run_case(2, 2, 2, 2, 50, 0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule